// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block owns the power-down state of a small processor core. When the instruction decoder reports a sleep command, the block stops the oscillator driver and gates the core clock. It also pulses a clear to the watchdog and updates two status bits. The first bit, pd_bit, marks that power-down was entered. The second, to_bit, reads low after a watchdog timeout. The block then watches a fixed set of wake events and decides how the core comes back to life.

A wake comes either from a reset-type event or from an interrupt. The reset-type events are the external reset pin and an enabled watchdog timeout. A reset-type wake ends in a one-cycle full device reset. An interrupt wake lets the core run the instruction that follows the sleep. When that instruction completes, the core either continues in line or takes the interrupt vector, depending on the global interrupt disable input. The global disable never blocks the wake itself. In the low-frequency and crystal oscillator modes, an oscillator start-up counter holds the core in reset for a fixed number of oscillator periods before either path continues. In the high-speed and RC modes there is no hold.

States: ST_RUN (core active), ST_SLEEP (oscillator off), ST_START_HOLD (start-up counter running), ST_RESET_PULSE (device reset cycle), ST_POST_INSN (post-sleep instruction running), ST_VECTOR (vector pulse). Transitions: RUN to SLEEP on sleep_cmd. SLEEP to START_HOLD on any wake when the mode needs a start-up hold. Otherwise, SLEEP goes straight to RESET_PULSE for a reset-type wake or to POST_INSN for an interrupt wake. START_HOLD goes to the same two targets when the counter expires. RESET_PULSE goes to RUN. POST_INSN goes to RUN on instr_done with glob_int_dis high, or to VECTOR on instr_done with glob_int_dis low. VECTOR goes to RUN.

Top module: `slp_ctl_top`

## Requirements
- R1: After power-on reset: pd_bit=1, to_bit=1, osc_en=1, core_clk_en=1, core_rst_hold=0, dev_reset=0, vector_take=0.
- R2: A sleep_cmd seen while running takes effect in the next cycle: osc_en=0, core_clk_en=0, pd_bit=0, to_bit=1.
- R3: While asleep, interrupt source i wakes the block only when int_en[i], int_flag[i] and WAKE_MASK[i] are all 1. The default mask 8'h0F makes sources 0 to 3 wake-capable and sources 4 to 7 not. glob_int_dis has no influence on the wake. Any other combination leaves the block asleep.
- R4: While asleep, wdt_timeout wakes the block only when wdt_en=1. Such a wake is reset-type and clears to_bit. wdt_timeout with wdt_en=0 leaves the block asleep.
- R5: While asleep, ext_rst_req wakes the block as a reset-type event. to_bit stays 1 and pd_bit stays 0.
- R6: wdt_clr is high in the cycle in which a sleep_cmd is accepted, and in the cycle in which any wake is accepted. It is low in every other cycle.
- R7: In osc_mode 2'b00 (low-frequency) or 2'b01 (crystal), a wake is followed by exactly OST_CYCLES (default 1024) cycles with core_rst_hold=1, osc_en=1 and core_clk_en=0. In osc_mode 2'b10 (high-speed) or 2'b11 (RC) there is no hold cycle.
- R8: A reset-type wake yields one cycle of dev_reset=1 with core_rst_hold=1 after any start-up hold. The next cycle is running: core_clk_en=1, core_rst_hold=0, dev_reset=0.
- R9: After an interrupt wake and any start-up hold, the core clock runs with core_rst_hold=0 and pd_bit=0, to_bit=1. An instr_done with glob_int_dis=1 returns to running without vector_take.
- R10: An instr_done with glob_int_dis=0 after an interrupt wake gives vector_take=1 for exactly one cycle, in the next cycle, with vector_addr=16'h0004. vector_addr is 0 whenever vector_take is 0.
- R11: When wake events coincide, ext_rst_req wins over an enabled watchdog timeout, and both win over interrupts.
- R12: sleep_cmd is ignored in every state other than running. In particular, a sleep_cmd during the post-sleep instruction leaves core_clk_en=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_cmd | input | 1 | Sleep command from the decoder |
| ext_rst_req | input | 1 | External reset pin request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog timeout event |
| int_en | input | NSRC | Per-source interrupt enables |
| int_flag | input | NSRC | Per-source interrupt flags |
| glob_int_dis | input | 1 | Global interrupt disable |
| osc_mode | input | 2 | 00 low-frequency, 01 crystal, 10 high-speed, 11 RC |
| instr_done | input | 1 | Post-sleep instruction completed |
| osc_en | output | 1 | Oscillator driver enable |
| core_clk_en | output | 1 | Core phase clock enable |
| core_rst_hold | output | 1 | Holds the core in reset |
| dev_reset | output | 1 | One-cycle full device reset |
| wdt_clr | output | 1 | Clears watchdog counter and postscaler |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |
| vector_take | output | 1 | Branch to interrupt vector |
| vector_addr | output | 16 | Vector address while vector_take |

## Verification
Most internal errors reach the ports within a cycle or two. A wrong state after a wake shows up at once as a wrong pattern of osc_en, core_clk_en and core_rst_hold. A wrongly latched wake kind stays hidden through the whole start-up hold. It only appears after the hold, as a dev_reset that should not occur or a missing one, so the bench follows every wake to its end. Status bit mistakes persist until the next sleep, so they are checked after each wake. A start-up counter that is off by one changes the count of hold cycles, which the bench measures exactly.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_SLEEP       = 3'd1,
        ST_START_HOLD  = 3'd2,
        ST_RESET_PULSE = 3'd3,
        ST_POST_INSN   = 3'd4,
        ST_VECTOR      = 3'd5
    } slp_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_EXT  = 2'd1,
        KIND_WDT  = 2'd2,
        KIND_INT  = 2'd3
    } wake_kind_e;

    typedef enum logic [1:0] {
        OSC_LF = 2'b00,
        OSC_XT = 2'b01,
        OSC_HS = 2'b10,
        OSC_RC = 2'b11
    } osc_mode_e;

    function automatic logic mode_needs_hold(input logic [1:0] mode);
        return (mode == OSC_LF) || (mode == OSC_XT);
    endfunction

    function automatic logic kind_is_reset(input wake_kind_e k);
        return (k == KIND_EXT) || (k == KIND_WDT);
    endfunction

endpackage

// File: rtl/slp_wake_eval.sv
module slp_wake_eval
    import slp_pkg::*;
#(
    parameter int                NSRC      = 8,
    parameter logic [NSRC-1:0]   WAKE_MASK = 8'h0F
) (
    input  logic            ext_rst_req,
    input  logic            wdt_en,
    input  logic            wdt_timeout,
    input  logic [NSRC-1:0] int_en,
    input  logic [NSRC-1:0] int_flag,
    output logic            wake_any,
    output wake_kind_e      wake_kind
);

    logic [NSRC-1:0] cand;

    // Only sources that can still signal without phase clocks may wake.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (WAKE_MASK[i]) begin : g_capable
            assign cand[i] = int_en[i] & int_flag[i];
        end else begin : g_blocked
            assign cand[i] = 1'b0;
        end
    end

    always_comb begin
        if (ext_rst_req) begin
            wake_kind = KIND_EXT;
        end else if (wdt_en && wdt_timeout) begin
            wake_kind = KIND_WDT;
        end else if (|cand) begin
            wake_kind = KIND_INT;
        end else begin
            wake_kind = KIND_NONE;
        end
    end

    assign wake_any = (wake_kind != KIND_NONE);

endmodule

// File: rtl/slp_ost_counter.sv
module slp_ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);

    localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(OST_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/slp_status_regs.sv
module slp_status_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_sleep,
    input  logic wdt_wake,
    output logic pd_bit,
    output logic to_bit
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_bit <= 1'b1;
            to_bit <= 1'b1;
        end else if (enter_sleep) begin
            pd_bit <= 1'b0;
            to_bit <= 1'b1;
        end else if (wdt_wake) begin
            to_bit <= 1'b0;
        end
    end

endmodule

// File: rtl/slp_ctl_top.sv
module slp_ctl_top
    import slp_pkg::*;
#(
    parameter int              NSRC       = 8,
    parameter logic [NSRC-1:0] WAKE_MASK  = 8'h0F,
    parameter int              OST_CYCLES = 1024,
    parameter logic [15:0]     VEC_ADDR   = 16'h0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_cmd,
    input  logic            ext_rst_req,
    input  logic            wdt_en,
    input  logic            wdt_timeout,
    input  logic [NSRC-1:0] int_en,
    input  logic [NSRC-1:0] int_flag,
    input  logic            glob_int_dis,
    input  logic [1:0]      osc_mode,
    input  logic            instr_done,
    output logic            osc_en,
    output logic            core_clk_en,
    output logic            core_rst_hold,
    output logic            dev_reset,
    output logic            wdt_clr,
    output logic            pd_bit,
    output logic            to_bit,
    output logic            vector_take,
    output logic [15:0]     vector_addr
);

    slp_state_e state_q, state_d;
    wake_kind_e kind_q, kind_d;
    wake_kind_e wake_kind;
    logic       wake_any;
    logic       wake_acc;
    logic       ost_load;
    logic       ost_done;

    slp_wake_eval #(
        .NSRC      (NSRC),
        .WAKE_MASK (WAKE_MASK)
    ) u_wake (
        .ext_rst_req (ext_rst_req),
        .wdt_en      (wdt_en),
        .wdt_timeout (wdt_timeout),
        .int_en      (int_en),
        .int_flag    (int_flag),
        .wake_any    (wake_any),
        .wake_kind   (wake_kind)
    );

    assign wake_acc = (state_q == ST_SLEEP) && wake_any;
    assign ost_load = wake_acc && mode_needs_hold(osc_mode);

    slp_ost_counter #(
        .OST_CYCLES (OST_CYCLES)
    ) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ost_load),
        .run   (state_q == ST_START_HOLD),
        .done  (ost_done)
    );

    slp_status_regs u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_sleep ((state_q == ST_RUN) && sleep_cmd),
        .wdt_wake    (wake_acc && (wake_kind == KIND_WDT)),
        .pd_bit      (pd_bit),
        .to_bit      (to_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            kind_q  <= KIND_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_cmd) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (wake_any) begin
                    kind_d = wake_kind;
                    if (mode_needs_hold(osc_mode)) begin
                        state_d = ST_START_HOLD;
                    end else if (kind_is_reset(wake_kind)) begin
                        state_d = ST_RESET_PULSE;
                    end else begin
                        state_d = ST_POST_INSN;
                    end
                end
            end
            ST_START_HOLD: begin
                if (ost_done) begin
                    state_d = kind_is_reset(kind_q) ? ST_RESET_PULSE : ST_POST_INSN;
                end
            end
            ST_RESET_PULSE: begin
                state_d = ST_RUN;
            end
            ST_POST_INSN: begin
                if (instr_done) begin
                    state_d = glob_int_dis ? ST_RUN : ST_VECTOR;
                end
            end
            ST_VECTOR: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        osc_en        = 1'b1;
        core_clk_en   = 1'b0;
        core_rst_hold = 1'b0;
        dev_reset     = 1'b0;
        vector_take   = 1'b0;
        unique case (state_q)
            ST_RUN:         core_clk_en = 1'b1;
            ST_SLEEP:       osc_en = 1'b0;
            ST_START_HOLD:  core_rst_hold = 1'b1;
            ST_RESET_PULSE: begin
                core_rst_hold = 1'b1;
                dev_reset     = 1'b1;
            end
            ST_POST_INSN:   core_clk_en = 1'b1;
            ST_VECTOR: begin
                core_clk_en = 1'b1;
                vector_take = 1'b1;
            end
            default:        core_clk_en = 1'b1;
        endcase
        wdt_clr     = ((state_q == ST_RUN) && sleep_cmd) || wake_acc;
        vector_addr = vector_take ? VEC_ADDR : 16'h0000;
    end

endmodule

// File: rtl/slp_ctl_chk.sv
module slp_ctl_chk
    import slp_pkg::*;
#(
    parameter int              NSRC      = 8,
    parameter logic [NSRC-1:0] WAKE_MASK = 8'h0F
) (
    input logic            clk,
    input logic            rst_n,
    input slp_state_e      state_q,
    input logic            sleep_cmd,
    input logic            ext_rst_req,
    input logic            wdt_en,
    input logic            wdt_timeout,
    input logic [NSRC-1:0] int_en,
    input logic [NSRC-1:0] int_flag,
    input logic            osc_en,
    input logic            core_clk_en,
    input logic            core_rst_hold,
    input logic            dev_reset,
    input logic            wdt_clr,
    input logic            pd_bit,
    input logic            to_bit,
    input logic            vector_take,
    input logic [15:0]     vector_addr
);

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_cmd) |=> (!osc_en && !core_clk_en && !pd_bit && to_bit)); // R2
    AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !ext_rst_req && !(wdt_en && wdt_timeout)
         && ((int_en & int_flag & WAKE_MASK) == '0)) |=> (state_q == ST_SLEEP)); // R3
    AST_WDT_WAKE_CLEARS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !ext_rst_req && wdt_en && wdt_timeout) |=> !to_bit); // R4
    AST_EXT_WAKE_KEEPS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && ext_rst_req) |=> (to_bit && !pd_bit && state_q != ST_SLEEP)); // R5
    AST_WDT_CLR_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && ext_rst_req) |-> wdt_clr); // R6
    AST_HOLD_GATES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_hold |-> (osc_en && !core_clk_en)); // R7
    AST_RESET_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (core_clk_en && !core_rst_hold && !dev_reset)); // R8
    AST_VECTOR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        vector_take |=> !vector_take); // R10
    AST_VECTOR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        vector_take |-> (vector_addr == 16'h0004)); // R10
    AST_SLEEP_IGNORED_POST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST_INSN && sleep_cmd) |=> osc_en); // R12

endmodule

bind slp_ctl_top slp_ctl_chk #(
    .NSRC      (NSRC),
    .WAKE_MASK (WAKE_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (state_q),
    .sleep_cmd     (sleep_cmd),
    .ext_rst_req   (ext_rst_req),
    .wdt_en        (wdt_en),
    .wdt_timeout   (wdt_timeout),
    .int_en        (int_en),
    .int_flag      (int_flag),
    .osc_en        (osc_en),
    .core_clk_en   (core_clk_en),
    .core_rst_hold (core_rst_hold),
    .dev_reset     (dev_reset),
    .wdt_clr       (wdt_clr),
    .pd_bit        (pd_bit),
    .to_bit        (to_bit),
    .vector_take   (vector_take),
    .vector_addr   (vector_addr)
);

// File: tb/slp_ctl_top_tb_top.sv
module slp_ctl_top_tb_top;

    localparam int          NSRC = 8;
    localparam logic [7:0]  MASK = 8'h0F;
    localparam int          OSTC = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_cmd = 1'b0;
    logic            ext_rst_req = 1'b0;
    logic            wdt_en = 1'b0;
    logic            wdt_timeout = 1'b0;
    logic [NSRC-1:0] int_en = '0;
    logic [NSRC-1:0] int_flag = '0;
    logic            glob_int_dis = 1'b0;
    logic [1:0]      osc_mode = 2'b11;
    logic            instr_done = 1'b0;
    logic            osc_en, core_clk_en, core_rst_hold, dev_reset, wdt_clr;
    logic            pd_bit, to_bit, vector_take;
    logic [15:0]     vector_addr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    slp_ctl_top #(.NSRC(NSRC), .WAKE_MASK(MASK), .OST_CYCLES(OSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .ext_rst_req(ext_rst_req),
        .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .int_en(int_en), .int_flag(int_flag),
        .glob_int_dis(glob_int_dis), .osc_mode(osc_mode), .instr_done(instr_done),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .core_rst_hold(core_rst_hold),
        .dev_reset(dev_reset), .wdt_clr(wdt_clr), .pd_bit(pd_bit), .to_bit(to_bit),
        .vector_take(vector_take), .vector_addr(vector_addr)
    );

    // 0 none, 1 ext, 2 wdt, 3 int
    function automatic int exp_kind(input logic e, input logic we, input logic wt,
                                    input logic [7:0] en, input logic [7:0] fl);
        if (e) return 1;
        if (we && wt) return 2;
        if ((en & fl & MASK) != 8'h00) return 3;
        return 0;
    endfunction

    function automatic int exp_hold(input logic [1:0] m);
        return (m == 2'b00 || m == 2'b01) ? OSTC : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_wake();
        ext_rst_req = 1'b0; wdt_timeout = 1'b0; wdt_en = 1'b0;
        int_en = '0; int_flag = '0;
    endtask

    task automatic scenario(input logic [1:0] m, input logic e, input logic we,
                            input logic wt, input logic [7:0] en, input logic [7:0] fl,
                            input logic gd);
        int k;
        int hc;
        osc_mode = m;
        sleep_cmd = 1'b1;
        #1 chk("R6", "wdt_clr on sleep", int'(wdt_clr), 1);
        tick(); sleep_cmd = 1'b0;
        chk("R2", "asleep osc/clk", int'({osc_en, core_clk_en}), 0);
        chk("R2", "pd/to after sleep", int'({pd_bit, to_bit}), 1);
        ext_rst_req = e; wdt_en = we; wdt_timeout = wt; int_en = en; int_flag = fl;
        glob_int_dis = gd;
        k = exp_kind(e, we, wt, en, fl);
        #1;
        if (k == 0) begin
            chk("R3", "no wake -> wdt_clr low", int'(wdt_clr), 0);
            tick();
            chk("R3", "stays asleep", int'(osc_en), 0);
            chk("R4", "stays asleep", int'(core_clk_en), 0);
            clear_wake(); int_en = 8'h01; int_flag = 8'h01; k = 3;
            #1;
        end
        chk("R6", "wdt_clr on wake", int'(wdt_clr), 1);
        tick(); clear_wake();
        if (exp_hold(m) != 0)
            chk("R7", "hold osc/clk", int'({osc_en, core_clk_en}), 2);
        hc = 0;
        while (core_rst_hold && !dev_reset && hc < 5000) begin
            hc++; tick();
        end
        chk("R7", "hold cycles", hc, exp_hold(m));
        if (k == 1 || k == 2) begin
            chk("R8", "dev_reset pulse", int'(dev_reset), 1);
            chk(k == 2 ? "R4" : "R5", "to_bit after reset wake", int'(to_bit), k == 2 ? 0 : 1);
            chk("R11", "wake kind via to_bit", int'(to_bit), k == 1 ? 1 : 0);
            tick();
            chk("R8", "run after reset", int'({core_clk_en, core_rst_hold, dev_reset}), 4);
        end else begin
            chk("R11", "int wake no dev_reset", int'(dev_reset), 0);
            chk("R9", "post insn clk/hold", int'({core_clk_en, core_rst_hold}), 2);
            chk("R9", "pd/to after int wake", int'({pd_bit, to_bit}), 1);
            sleep_cmd = 1'b1; tick(); sleep_cmd = 1'b0;
            chk("R12", "sleep ignored post", int'({osc_en, core_clk_en}), 3);
            instr_done = 1'b1; tick(); instr_done = 1'b0;
            if (!gd) begin
                chk("R10", "vector_take", int'(vector_take), 1);
                chk("R10", "vector_addr", int'(vector_addr), 16'h0004);
                tick();
                chk("R10", "vector one cycle", int'(vector_take), 0);
            end else begin
                chk("R9", "no vector when disabled", int'(vector_take), 0);
                chk("R10", "addr zero", int'(vector_addr), 0);
            end
        end
        chk("R12", "running again", int'(core_clk_en), 1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        tick(); tick();
        chk("R1", "reset pd/to", int'({pd_bit, to_bit}), 3);
        rst_n = 1'b1;
        tick();
        chk("R1", "reset outputs", int'({osc_en, core_clk_en, core_rst_hold, dev_reset, vector_take}), 24);
        // directed corners
        scenario(2'b11, 0, 0, 0, 8'h20, 8'h20, 0);  // R3 non-capable source
        scenario(2'b10, 0, 0, 1, 8'h00, 8'h00, 1);  // R4 timeout without enable
        scenario(2'b11, 0, 0, 0, 8'h04, 8'h04, 1);  // R3 wake with global disable
        scenario(2'b00, 0, 1, 1, 8'h00, 8'h00, 0);  // R4 watchdog wake with hold
        scenario(2'b01, 1, 0, 0, 8'h00, 8'h00, 0);  // R5 external reset
        scenario(2'b11, 1, 1, 1, 8'hFF, 8'hFF, 0);  // R11 all at once
        scenario(2'b10, 0, 1, 1, 8'h02, 8'h02, 0);  // R11 wdt over int
        scenario(2'b00, 0, 0, 0, 8'h08, 8'h08, 0);  // R7 R10 int with hold
        for (int i = 0; i < 40; i++) begin
            logic [1:0] m  = 2'($urandom_range(0, 3));
            logic       e  = ($urandom_range(0, 7) == 0);
            logic       we = 1'($urandom);
            logic       wt = ($urandom_range(0, 3) == 0);
            logic [7:0] en = 8'($urandom);
            logic [7:0] fl = 8'($urandom) & 8'($urandom);
            logic       gd = 1'($urandom);
            scenario(m, e, we, wt, en, fl, gd);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule